// File: doc/BRIEF.md
# Streaming Block-Cipher Chaining Controller

This block turns an iterative block cipher with a start/done handshake into a streaming encryptor and decryptor. A single feedback state register feeds the cipher input. One multiplexer picks the rule that updates that register after each block. That rule is either counting (counter mode), cipher feedback, or block chaining. The forward cipher alone serves every supported direction: counter and cipher-feedback decryption need only the forward transform, and block chaining is provided for encryption only.

Software first loads an initial vector, together with the chaining mode and the direction. It then presents message blocks one at a time with a valid strobe, and a ready signal holds them off while the cipher runs. Each finished block appears on the output with a one-cycle valid strobe. The output data then holds until the next result. The enclosed cipher is a keyed add-rotate-xor permutation iterated a fixed number of rounds, one round per clock.

Top module: `cipher_mode_ctrl`

## Requirements
- R1: While reset is held, and for two clock edges after it is released, out_valid_o and in_ready_o are 0. out_data_o is 0 from reset until the first result.
- R2: Mode code 2'b00 (counter): the state starts at the loaded vector and rises by one after each block. Each output is the input block xor E(state).
- R3: In counter mode the direction input has no effect, so decrypting a ciphertext stream from the same vector returns the plaintext.
- R4: Mode code 2'b01 with direction 0 (cipher-feedback encrypt): output = input xor E(previous output), and the first block uses the loaded vector in place of the previous output.
- R5: Mode code 2'b01 with direction 1 (cipher-feedback decrypt): output = input xor E(previous input block), and the first block uses the loaded vector; decrypting a cipher-feedback ciphertext returns the plaintext.
- R6: Mode code 2'b10 (block chaining): output = E(input xor previous output), and the first block uses the loaded vector. Direction is ignored in this mode. Mode code 2'b11 behaves as counter mode.
- R7: A vector load (iv_load_i high while in_ready would otherwise be high) replaces the state with iv_i and samples mode_i and decrypt_i. Changes on mode_i or decrypt_i at any other time have no effect.
- R8: in_ready_o falls on the edge that accepts a block and stays low until the result is presented. Input strobes and vector loads made while it is low are ignored. A vector load takes the cycle, so a block strobe in the same cycle is not accepted.
- R9: out_valid_o is a one-cycle pulse. It rises ROUNDS+1 clock edges after the accepting edge. out_data_o changes only together with that pulse.
- R10: The counter wraps modulo 2^W, so all-ones is followed by zero.
- R11: E(x) applies ROUNDS rounds, for round index i = 0 upward: x = rotl(x xor key, ROT) + (i+1) mod 2^W, where rotl is a left rotation. Defaults: W=32, ROUNDS=4, ROT=5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_i | input | W | Cipher key |
| iv_load_i | input | 1 | Load initial vector, mode and direction |
| iv_i | input | W | Initial vector |
| mode_i | input | 2 | Chaining mode code |
| decrypt_i | input | 1 | Direction, 1 = decrypt |
| in_valid_i | input | 1 | Input block strobe |
| in_data_i | input | W | Input block |
| in_ready_o | output | 1 | Block or vector load can be taken |
| out_valid_o | output | 1 | Result strobe, one cycle |
| out_data_o | output | W | Result block, held between strobes |

## Verification
The properties assume that key_i does not change while a block is in flight and that iv_i is meaningful whenever iv_load_i is raised. The bench keeps the key constant for the whole run. It changes mode, direction and vector only at defined points: while idle, or on purpose while busy to show that they are ignored. All inputs are driven on the falling clock edge, so every handshake resolves cleanly at the next rising edge.

// File: rtl/cipher_mode_pkg.sv
package cipher_mode_pkg;
  typedef enum logic [1:0] {
    CM_CTR     = 2'd0,
    CM_CFB     = 2'd1,
    CM_CBC     = 2'd2,
    CM_CTR_ALT = 2'd3
  } chain_mode_e;
endpackage

// File: rtl/cmc_round_engine.sv
module cmc_round_engine #(
  parameter int W      = 32,
  parameter int ROUNDS = 4,
  parameter int ROT    = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] key_i,
  input  logic         start_i,
  input  logic [W-1:0] din_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] dout_o
);
  localparam int RW = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
  localparam logic [RW-1:0] LAST = RW'(ROUNDS - 1);

  logic [W-1:0]  x_q, x_d;
  logic [RW-1:0] rnd_q, rnd_d;
  logic          busy_q, busy_d, done_q, done_d;
  logic [W-1:0]  mixed;

  always_comb begin
    mixed  = x_q ^ key_i;
    x_d    = x_q;
    rnd_d  = rnd_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (busy_q) begin
      x_d   = ((mixed << ROT) | (mixed >> (W - ROT))) + W'(rnd_q) + W'(1);
      rnd_d = rnd_q + RW'(1);
      if (rnd_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end else if (start_i) begin
      x_d    = din_i;
      rnd_d  = '0;
      busy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      rnd_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      x_q    <= x_d;
      rnd_q  <= rnd_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign dout_o = x_q;
endmodule

// File: rtl/cmc_chain_reg.sv
module cmc_chain_reg
  import cipher_mode_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] iv_i,
  input  logic         advance_i,
  input  chain_mode_e  mode_i,
  input  logic         decrypt_i,
  input  logic [W-1:0] rx_blk_i,
  input  logic [W-1:0] result_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q, state_d;
  logic         en;

  assign en = load_i | advance_i;

  always_comb begin
    state_d = state_q;
    if (load_i) begin
      state_d = iv_i;
    end else begin
      unique case (mode_i)
        CM_CFB:  state_d = decrypt_i ? rx_blk_i : result_i;
        CM_CBC:  state_d = result_i;
        default: state_d = state_q + W'(1);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else if (en) state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/cipher_mode_ctrl.sv
module cipher_mode_ctrl
  import cipher_mode_pkg::*;
#(
  parameter int W      = 32,
  parameter int ROUNDS = 4,
  parameter int ROT    = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] key_i,
  input  logic         iv_load_i,
  input  logic [W-1:0] iv_i,
  input  logic [1:0]   mode_i,
  input  logic         decrypt_i,
  input  logic         in_valid_i,
  input  logic [W-1:0] in_data_i,
  output logic         in_ready_o,
  output logic         out_valid_o,
  output logic [W-1:0] out_data_o
);
  logic [1:0]   rst_sync_q;
  logic         rst_q_n;
  logic         busy_q, busy_d;
  chain_mode_e  mode_q;
  logic         dec_q;
  logic [W-1:0] blk_q;
  logic [W-1:0] out_data_q, out_data_d;
  logic         out_valid_q;
  logic         accept, iv_take;
  logic [W-1:0] state_q, core_din, core_dout, result;
  logic         core_busy, core_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  assign in_ready_o = rst_q_n & ~busy_q & ~iv_load_i;
  assign accept     = in_valid_i & in_ready_o;
  assign iv_take    = rst_q_n & iv_load_i & ~busy_q;

  assign core_din = (mode_q == CM_CBC) ? (state_q ^ in_data_i) : state_q;
  assign result   = (mode_q == CM_CBC) ? core_dout : (blk_q ^ core_dout);

  always_comb begin
    busy_d     = busy_q;
    out_data_d = out_data_q;
    if (accept)    busy_d = 1'b1;
    if (core_done) begin
      busy_d     = 1'b0;
      out_data_d = result;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      busy_q      <= 1'b0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
      mode_q      <= CM_CTR;
      dec_q       <= 1'b0;
      blk_q       <= '0;
    end else begin
      busy_q      <= busy_d;
      out_valid_q <= core_done;
      if (core_done) out_data_q <= out_data_d;
      if (accept)    blk_q      <= in_data_i;
      if (iv_take) begin
        mode_q <= chain_mode_e'(mode_i);
        dec_q  <= decrypt_i;
      end
    end
  end

  cmc_round_engine #(.W(W), .ROUNDS(ROUNDS), .ROT(ROT)) u_engine (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .key_i   (key_i),
    .start_i (accept),
    .din_i   (core_din),
    .busy_o  (core_busy),
    .done_o  (core_done),
    .dout_o  (core_dout)
  );

  cmc_chain_reg #(.W(W)) u_chain (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .load_i    (iv_take),
    .iv_i      (iv_i),
    .advance_i (core_done),
    .mode_i    (mode_q),
    .decrypt_i (dec_q),
    .rx_blk_i  (blk_q),
    .result_i  (result),
    .state_o   (state_q)
  );

  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_data_q;
endmodule

// File: rtl/cipher_mode_ctrl_chk.sv
module cipher_mode_ctrl_chk
  import cipher_mode_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         iv_load_i,
  input logic [W-1:0] iv_i,
  input logic         in_valid_i,
  input logic         in_ready_o,
  input logic         out_valid_o,
  input logic [W-1:0] out_data_o,
  input logic         busy_q,
  input logic         core_busy,
  input logic         core_done,
  input chain_mode_e  mode_q,
  input logic [W-1:0] state_q
);
  // R9: result strobe lasts one cycle
  a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |=> !out_valid_o);

  // R9: data moves only with the strobe
  a_r9_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid_o |-> $stable(out_data_o));

  // R8: ready drops after an accepted block
  a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_ready_o) |=> !in_ready_o);

  // R8: engine finishes only while the controller waits for it
  a_r8_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |-> (busy_q && !in_ready_o));

  // R8: engine never runs while the controller is idle
  a_r8_engine_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !core_busy);

  // R7: a vector load while idle replaces the state
  a_r7_iv_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (iv_load_i && !busy_q) |=> (state_q == $past(iv_i)));

  // R2 / R10: counter modes step by one, modulo 2^W
  a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (core_done && mode_q != CM_CFB && mode_q != CM_CBC) |=>
      (state_q == $past(state_q) + W'(1)));
endmodule

bind cipher_mode_ctrl cipher_mode_ctrl_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .iv_load_i   (iv_load_i),
  .iv_i        (iv_i),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o),
  .busy_q      (busy_q),
  .core_busy   (core_busy),
  .core_done   (core_done),
  .mode_q      (mode_q),
  .state_q     (state_q)
);

// File: tb/cipher_mode_ctrl_tb_top.sv
module cipher_mode_ctrl_tb_top;
  localparam int CLK_P  = 10;
  localparam int W      = 32;
  localparam int ROUNDS = 4;
  localparam int ROT    = 5;
  localparam logic [W-1:0] KEY = 32'hA5C3_0F1E;

  // {load[67], mode[66:65], dec[64], iv[63:32], data[31:0]}
  localparam int NV = 14;
  localparam logic [67:0] VEC [NV] = '{
    {1'b1, 2'd0, 1'b0, 32'h0000_1000, 32'h1111_2222},  // R2 counter
    {1'b0, 2'd0, 1'b0, 32'h0,         32'h3333_4444},  // R2
    {1'b0, 2'd0, 1'b0, 32'h0,         32'hDEAD_BEEF},  // R2
    {1'b1, 2'd1, 1'b0, 32'h7777_0001, 32'h0123_4567},  // R4 feedback enc
    {1'b0, 2'd1, 1'b0, 32'h0,         32'h89AB_CDEF},  // R4
    {1'b0, 2'd1, 1'b0, 32'h0,         32'h0000_0000},  // R4
    {1'b1, 2'd1, 1'b1, 32'h5555_AAAA, 32'hCAFE_F00D},  // R5 feedback dec
    {1'b0, 2'd1, 1'b1, 32'h0,         32'h1234_0000},  // R5
    {1'b1, 2'd2, 1'b0, 32'h0BAD_C0DE, 32'hFFFF_FFFF},  // R6 chaining
    {1'b0, 2'd2, 1'b0, 32'h0,         32'h0F0F_0F0F},  // R6
    {1'b0, 2'd2, 1'b0, 32'h0,         32'h0000_0001},  // R6
    {1'b1, 2'd2, 1'b1, 32'h0BAD_C0DE, 32'hFFFF_FFFF},  // R6 direction ignored
    {1'b1, 2'd3, 1'b0, 32'h0000_0042, 32'h9999_0000},  // R6 code 3 counts
    {1'b0, 2'd3, 1'b0, 32'h0,         32'h9999_0000}   // R6
  };

  logic         clk, rst_n;
  logic [W-1:0] key_i, iv_i, in_data_i, out_data_o;
  logic         iv_load_i, decrypt_i, in_valid_i, in_ready_o, out_valid_o;
  logic [1:0]   mode_i;

  int checks, errors;
  logic [W-1:0] m_state;
  logic [1:0]   m_mode;
  logic         m_dec;

  cipher_mode_ctrl #(.W(W), .ROUNDS(ROUNDS), .ROT(ROT)) dut_i (
    .clk(clk), .rst_n(rst_n), .key_i(key_i), .iv_load_i(iv_load_i), .iv_i(iv_i),
    .mode_i(mode_i), .decrypt_i(decrypt_i), .in_valid_i(in_valid_i),
    .in_data_i(in_data_i), .in_ready_o(in_ready_o), .out_valid_o(out_valid_o),
    .out_data_o(out_data_o)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  function automatic logic [W-1:0] ref_e(input logic [W-1:0] x);
    logic [W-1:0] v, t;
    v = x;
    for (int i = 0; i < ROUNDS; i++) begin
      t = v ^ KEY;
      v = {t[W-1-ROT:0], t[W-1:W-ROT]} + W'(i + 1);
    end
    return v;
  endfunction

  function automatic logic [W-1:0] ref_block(input logic [W-1:0] d);
    logic [W-1:0] r;
    if (m_mode == 2'd2) begin
      r = ref_e(m_state ^ d);
      m_state = r;
    end else if (m_mode == 2'd1) begin
      r = d ^ ref_e(m_state);
      m_state = m_dec ? d : r;
    end else begin
      r = d ^ ref_e(m_state);
      m_state = m_state + W'(1);
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_iv(input logic [W-1:0] iv, input logic [1:0] md, input logic dc);
    @(negedge clk);
    iv_load_i = 1'b1; iv_i = iv; mode_i = md; decrypt_i = dc;
    @(negedge clk);
    iv_load_i = 1'b0;
    m_state = iv; m_mode = md; m_dec = dc;
  endtask

  task automatic send(input logic [W-1:0] d, output logic [W-1:0] r, output int lat);
    @(negedge clk);
    in_valid_i = 1'b1; in_data_i = d;
    while (!in_ready_o) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid_i = 1'b0;
    lat = 0;
    while (!out_valid_o && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    r = out_data_o;
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] r, e, p0, p1, c0, c1;
    int lat;
    checks = 0; errors = 0;
    rst_n = 1'b0; key_i = KEY; iv_load_i = 1'b0; iv_i = '0; mode_i = 2'd0;
    decrypt_i = 1'b0; in_valid_i = 1'b0; in_data_i = '0;
    m_state = '0; m_mode = 2'd0; m_dec = 1'b0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", W'(in_ready_o), '0);
    chk("R1 valid in reset", W'(out_valid_o), '0);
    chk("R1 data in reset", out_data_o, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready during release", W'(in_ready_o), '0);
    repeat (2) @(negedge clk);
    chk("R1 ready after release", W'(in_ready_o), W'(1));
    chk("R1 data after release", out_data_o, '0);

    // table walk: R2 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][67]) load_iv(VEC[i][63:32], VEC[i][66:65], VEC[i][64]);
      send(VEC[i][31:0], r, lat);
      e = ref_block(VEC[i][31:0]);
      chk($sformatf("R2/R4/R5/R6 vector %0d", i), r, e);
    end

    // R11: single-block value pins the cipher function
    load_iv(32'h0, 2'd0, 1'b0);
    send(32'h0, r, lat);
    chk("R11 E(0)", r, ref_e(32'h0));

    // R9: latency, pulse width, hold
    load_iv(32'h0000_2000, 2'd0, 1'b0);
    send(32'h4444_5555, r, lat);
    e = ref_block(32'h4444_5555);
    chk("R9 latency", W'(lat), W'(ROUNDS + 1));
    chk("R9 ready with result", W'(in_ready_o), W'(1));
    @(negedge clk);
    chk("R9 pulse one cycle", W'(out_valid_o), '0);
    repeat (3) @(negedge clk);
    chk("R9 data held", out_data_o, e);

    // R10: counter wrap
    load_iv({W{1'b1}}, 2'd0, 1'b0);
    send(32'hAAAA_0000, r, lat);
    chk("R10 block at all-ones", r, 32'hAAAA_0000 ^ ref_e({W{1'b1}}));
    send(32'hAAAA_0001, r, lat);
    chk("R10 block after wrap", r, 32'hAAAA_0001 ^ ref_e('0));
    m_state = '0; m_mode = 2'd0;

    // R3: counter round trip with decrypt set
    p0 = 32'h1357_9BDF; p1 = 32'h2468_ACE0;
    load_iv(32'h0000_0777, 2'd0, 1'b0);
    send(p0, c0, lat); send(p1, c1, lat);
    load_iv(32'h0000_0777, 2'd0, 1'b1);
    send(c0, r, lat); chk("R3 counter decrypt 0", r, p0);
    send(c1, r, lat); chk("R3 counter decrypt 1", r, p1);

    // R5: feedback round trip
    load_iv(32'h3141_5926, 2'd1, 1'b0);
    send(p0, c0, lat); send(p1, c1, lat);
    load_iv(32'h3141_5926, 2'd1, 1'b1);
    send(c0, r, lat); chk("R5 feedback decrypt 0", r, p0);
    send(c1, r, lat); chk("R5 feedback decrypt 1", r, p1);

    // R7 + R8: mode change without load, strobes and load while busy
    load_iv(32'h0000_5000, 2'd0, 1'b0);
    @(negedge clk);
    in_valid_i = 1'b1; in_data_i = 32'h0F00_000F;
    @(negedge clk);  // accepted on the edge just passed
    chk("R8 ready low while busy", W'(in_ready_o), '0);
    in_data_i = 32'hFFFF_0000;         // strobe held high while busy
    iv_load_i = 1'b1; iv_i = 32'h9999_9999; mode_i = 2'd2;
    @(negedge clk);
    iv_load_i = 1'b0; in_valid_i = 1'b0;
    while (!out_valid_o) @(negedge clk);
    e = ref_block(32'h0F00_000F);
    chk("R8 result unaffected by busy strobes", out_data_o, e);
    send(32'h0000_0000, r, lat);
    e = ref_block(32'h0000_0000);
    chk("R7 mode and state kept without accepted load", r, e);

    // R8: load and block strobe in the same cycle
    @(negedge clk);
    iv_load_i = 1'b1; iv_i = 32'h0000_6000; mode_i = 2'd0; decrypt_i = 1'b0;
    in_valid_i = 1'b1; in_data_i = 32'h7777_7777;
    #1 chk("R8 ready low during load", W'(in_ready_o), '0);
    @(negedge clk);
    iv_load_i = 1'b0; in_valid_i = 1'b0;
    m_state = 32'h0000_6000; m_mode = 2'd0; m_dec = 1'b0;
    lat = 0;
    repeat (ROUNDS + 3) begin
      @(negedge clk);
      if (out_valid_o) lat++;
    end
    chk("R8 block with load not taken", W'(lat), '0);
    send(32'h1212_3434, r, lat);
    chk("R7 first block after load uses vector", r, 32'h1212_3434 ^ ref_e(32'h0000_6000));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule